// File: doc/BRIEF.md
# Bit-Order-Selectable Serial Register Port

This block is a three-wire serial slave that gives an external master read and write access to a file of 128 byte-wide registers. The serial data pin is bidirectional at the chip edge and appears here as a separate input, output and output enable. A transaction begins when the chip select goes low. It opens with an instruction byte that carries a read/write flag and a 7-bit address. One or more data bytes follow for as long as the select stays low. Between data bytes, an internal address counter steps to the next register.

Bit 6 of register 0x00 chooses the bit order on the wire. The same bit chooses the direction in which the multibyte address counter moves. With the bit clear, every byte travels most-significant bit first and the counter counts down. With the bit set, every byte travels least-significant bit first and the counter counts up. The instruction byte is the 8-bit word {flag, address}, so its field order flips with the mode. The mode is captured while the select is high, so a write to the mode bit changes nothing until the next transaction.

The serial inputs are synchronized to the system clock `clk`, and the serial clock's edges are detected in that domain. A parallel host port reads the same register file combinationally and writes it on the clock edge. The control sequence has four states. IDLE moves to INSTR once the select is seen low. INSTR moves to WDATA or RDATA after the eighth instruction bit, according to the flag. WDATA and RDATA stay in place across byte boundaries. Any state returns to IDLE as soon as the select is seen high.

Top module: `spi_regport`

## Requirements
- R1: After reset every register reads 0x00 on the host port, `spi_sdo_oe` is 0, and bit 6 of register 0x00 is 0, which selects MSB-first mode.
- R2: The instruction byte is {rw, addr[6:0]}, with rw = 1 meaning read. In MSB-first mode it is sent rw, A6 … A0. In LSB-first mode it is sent A0 … A6, then rw.
- R3: Data bytes, whether written to the block or read from it, travel bit 7 first in MSB-first mode and bit 0 first in LSB-first mode.
- R4: In MSB-first mode the instruction address is used for the first data byte. The address then decrements after every byte and wraps from 0x00 to 0x7F.
- R5: In LSB-first mode the instruction address is used for the first data byte. The address then increments after every byte and wraps from 0x7F to 0x00.
- R6: Input bits are taken on rising edges of `spi_sclk`. Read data on `spi_sdo` changes only after a falling edge and holds through the following high phase.
- R7: Raising `spi_cs_n` abandons any partial instruction or data byte. A partial data byte never reaches a register, and the next transaction starts with a fresh instruction.
- R8: A write to bit 6 of register 0x00 leaves the bit order and the counting direction unchanged for the rest of the current transaction. It applies from the next transaction on.
- R9: `spi_sdo_oe` is 1 only during the data phase of a read. It is 0 during writes and instructions, and 0 once the select is high.
- R10: `host_rdata` always shows the register at `host_addr`. A clock edge with `host_we` = 1 stores `host_wdata` at `host_addr`, and the new value is visible on both the host and the serial port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sclk | input | 1 | Serial clock from the master, idles low |
| spi_sdi | input | 1 | Serial data into the block |
| spi_sdo | output | 1 | Serial data out of the block |
| spi_sdo_oe | output | 1 | Drive enable for the serial data pin |
| host_addr | input | 7 | Host port register address |
| host_wdata | input | 8 | Host port write data |
| host_we | input | 1 | Host port write strobe |
| host_rdata | output | 8 | Host port read data, combinational |

## Verification
A wrong mode latch or address counter does not stay hidden. It puts a byte at an unexpected register, which the host port shows right after the select rises. On a multibyte read it returns the wrong register's contents, first visible on the second byte. A wrong shift direction mirrors the bits of the very first byte, and a wrong instruction decode sends that byte to a mirrored address. An output enable or data bit that moves at the wrong time shows on the pin within the same serial clock period. It is sampled at the end of each low phase and checked again at the end of the following high phase.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    // Control sequence of the serial port
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INSTR = 2'd1,
        ST_WDATA = 2'd2,
        ST_RDATA = 2'd3
    } spi_phase_e;

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic cs_n_o,
    output logic sdi_o,
    output logic sclk_rise_o,
    output logic sclk_fall_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] cs_pipe;
    logic [STAGES-1:0] sclk_pipe;
    logic [STAGES-1:0] sdi_pipe;
    logic              sclk_prev;

    if (STAGES == 1) begin : g_single
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cs_pipe   <= '1;
                sclk_pipe <= '0;
                sdi_pipe  <= '0;
            end else begin
                cs_pipe   <= cs_n_i;
                sclk_pipe <= sclk_i;
                sdi_pipe  <= sdi_i;
            end
        end
    end else begin : g_chain
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cs_pipe   <= '1;
                sclk_pipe <= '0;
                sdi_pipe  <= '0;
            end else begin
                cs_pipe   <= {cs_pipe[STAGES-2:0], cs_n_i};
                sclk_pipe <= {sclk_pipe[STAGES-2:0], sclk_i};
                sdi_pipe  <= {sdi_pipe[STAGES-2:0], sdi_i};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_pipe[LAST];
    end

    assign cs_n_o      = cs_pipe[LAST];
    assign sdi_o       = sdi_pipe[LAST];
    assign sclk_rise_o = sclk_pipe[LAST] & ~sclk_prev;
    assign sclk_fall_o = ~sclk_pipe[LAST] & sclk_prev;

endmodule

// File: rtl/spi_regfile.sv
module spi_regfile #(
    parameter int AW       = 7,
    parameter int DW       = 8,
    parameter int CFG_ADDR = 0,
    parameter int CFG_BIT  = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_we,
    input  logic [AW-1:0] spi_addr,
    input  logic [DW-1:0] spi_wdata,
    output logic [DW-1:0] spi_rdata,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          cfg_lsb
);
    localparam int DEPTH = 1 << AW;

    logic [DEPTH-1:0][DW-1:0] mem;

    // One storage word per entry; the serial port wins a same-entry collision
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[e] <= '0;
            end else if (spi_we && (spi_addr == AW'(e))) begin
                mem[e] <= spi_wdata;
            end else if (host_we && (host_addr == AW'(e))) begin
                mem[e] <= host_wdata;
            end
        end
    end

    assign spi_rdata  = mem[spi_addr];
    assign host_rdata = mem[host_addr];
    assign cfg_lsb    = mem[CFG_ADDR][CFG_BIT];

endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
    import spi_regport_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sdi,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    input  logic          cfg_lsb,
    input  logic [DW-1:0] rd_byte,
    output logic          reg_we,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          sdo,
    output logic          sdo_oe,
    output spi_phase_e    phase,
    output logic          lsb_mode
);
    localparam int              CNT_W    = $clog2(DW);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW - 1);

    spi_phase_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [DW-1:0]    sh_q, sh_d;
    logic [AW-1:0]    addr_q, addr_d;
    logic             lsb_q, lsb_d;
    logic             sdo_q, sdo_d;

    logic [DW-1:0]    sh_in;
    logic [AW-1:0]    addr_step;
    logic [CNT_W-1:0] tx_idx;
    logic             byte_end;
    logic             we_c;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            sh_q   <= '0;
            addr_q <= '0;
            lsb_q  <= 1'b0;
            sdo_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            sh_q   <= sh_d;
            addr_q <= addr_d;
            lsb_q  <= lsb_d;
            sdo_q  <= sdo_d;
        end
    end

    // Bit assembly is the same for both orders: the byte ends up as {bit7..bit0}
    assign sh_in     = lsb_q ? {sdi, sh_q[DW-1:1]} : {sh_q[DW-2:0], sdi};
    assign addr_step = lsb_q ? addr_q + 1'b1 : addr_q - 1'b1;
    assign tx_idx    = lsb_q ? cnt_q : LAST_BIT - cnt_q;
    assign byte_end  = sclk_rise && (cnt_q == LAST_BIT);

    // Next state and outputs
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        sh_d   = sh_q;
        addr_d = addr_q;
        lsb_d  = lsb_q;
        sdo_d  = sdo_q;
        we_c   = 1'b0;
        if (cs_n) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
            lsb_d = cfg_lsb;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    st_d  = ST_INSTR;
                    cnt_d = '0;
                end
                ST_INSTR: begin
                    if (sclk_rise) begin
                        sh_d  = sh_in;
                        cnt_d = cnt_q + 1'b1;
                    end
                    if (byte_end) begin
                        addr_d = sh_in[AW-1:0];
                        cnt_d  = '0;
                        st_d   = sh_in[DW-1] ? ST_RDATA : ST_WDATA;
                    end
                end
                ST_WDATA: begin
                    if (sclk_rise) begin
                        sh_d  = sh_in;
                        cnt_d = cnt_q + 1'b1;
                    end
                    if (byte_end) begin
                        we_c   = 1'b1;
                        addr_d = addr_step;
                        cnt_d  = '0;
                    end
                end
                ST_RDATA: begin
                    if (sclk_fall) sdo_d = rd_byte[tx_idx];
                    if (sclk_rise) cnt_d = cnt_q + 1'b1;
                    if (byte_end) begin
                        addr_d = addr_step;
                        cnt_d  = '0;
                    end
                end
            endcase
        end
    end

    assign reg_we    = we_c;
    assign reg_addr  = addr_q;
    assign reg_wdata = sh_in;
    assign sdo       = sdo_q;
    assign sdo_oe    = (st_q == ST_RDATA) && !cs_n;
    assign phase     = st_q;
    assign lsb_mode  = lsb_q;

endmodule

// File: rtl/spi_regport.sv
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int AW          = 7,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_cs_n,
    input  logic          spi_sclk,
    input  logic          spi_sdi,
    output logic          spi_sdo,
    output logic          spi_sdo_oe,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_we,
    output logic [DW-1:0] host_rdata
);
    logic          cs_n_s;
    logic          sdi_s;
    logic          sclk_rise;
    logic          sclk_fall;
    logic          cfg_lsb;
    logic          spi_we;
    logic [AW-1:0] spi_addr;
    logic [DW-1:0] spi_wdata;
    logic [DW-1:0] spi_rdata;
    spi_phase_e    phase;
    logic          lsb_mode;

    spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (spi_cs_n),
        .sclk_i     (spi_sclk),
        .sdi_i      (spi_sdi),
        .cs_n_o     (cs_n_s),
        .sdi_o      (sdi_s),
        .sclk_rise_o(sclk_rise),
        .sclk_fall_o(sclk_fall)
    );

    spi_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n_s),
        .sdi      (sdi_s),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .cfg_lsb  (cfg_lsb),
        .rd_byte  (spi_rdata),
        .reg_we   (spi_we),
        .reg_addr (spi_addr),
        .reg_wdata(spi_wdata),
        .sdo      (spi_sdo),
        .sdo_oe   (spi_sdo_oe),
        .phase    (phase),
        .lsb_mode (lsb_mode)
    );

    spi_regfile #(.AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_we    (spi_we),
        .spi_addr  (spi_addr),
        .spi_wdata (spi_wdata),
        .spi_rdata (spi_rdata),
        .host_we   (host_we),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .cfg_lsb   (cfg_lsb)
    );

endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk
    import spi_regport_pkg::*;
#(
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          sclk_rise,
    input logic          sclk_fall,
    input logic          spi_we,
    input logic [AW-1:0] addr,
    input logic          lsb_mode,
    input spi_phase_e    phase,
    input logic          sdo,
    input logic          sdo_oe
);
    // R7: no register write while deselected
    assert_no_write_deselected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !spi_we);

    // R6: a serial write lands only on a detected rising edge
    assert_write_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_we |-> sclk_rise);

    // R6: read data moves only after a falling edge
    assert_sdo_after_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(sdo));

    // R8: mode is frozen inside a transaction
    assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != ST_IDLE) |=> (phase == ST_IDLE) || $stable(lsb_mode));

    // R4: counting down in MSB-first mode
    assert_addr_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_we && !lsb_mode) |=> addr == AW'($past(addr) - 1'b1));

    // R5: counting up in LSB-first mode
    assert_addr_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_we && lsb_mode) |=> addr == AW'($past(addr) + 1'b1));

    // R9: driving starts right after an instruction byte closes on a rising edge
    assert_oe_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> $past(sclk_rise));

endmodule

bind spi_regport spi_regport_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n_s),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .spi_we   (spi_we),
    .addr     (spi_addr),
    .lsb_mode (lsb_mode),
    .phase    (phase),
    .sdo      (spi_sdo),
    .sdo_oe   (spi_sdo_oe)
);

// File: tb/spi_regport_tb.sv
module spi_regport_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_sclk = 1'b0;
    logic       spi_sdi = 1'b0;
    logic       spi_sdo;
    logic       spi_sdo_oe;
    logic [6:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       host_we = 1'b0;
    logic [7:0] host_rdata;

    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    logic [7:0] model [128];
    bit         model_lsb;
    logic [7:0] tx_buf [8];

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_regport u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_cs_n  (spi_cs_n),
        .spi_sclk  (spi_sclk),
        .spi_sdi   (spi_sdi),
        .spi_sdo   (spi_sdo),
        .spi_sdo_oe(spi_sdo_oe),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .host_we   (host_we),
        .host_rdata(host_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] step(input logic [6:0] a, input bit lsb);
        return lsb ? a + 7'd1 : a - 7'd1;
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_peek(input logic [6:0] a, output logic [7:0] v);
        @(negedge clk);
        host_addr = a;
        #1;
        v = host_rdata;
    endtask

    task automatic host_poke(input logic [6:0] a, input logic [7:0] v);
        @(negedge clk);
        host_addr  = a;
        host_wdata = v;
        host_we    = 1'b1;
        @(negedge clk);
        host_we    = 1'b0;
        model[a]   = v;
    endtask

    task automatic send_bit(input logic b);
        spi_sdi = b;
        wait_clk(HALF);
        spi_sclk = 1'b1;
        wait_clk(HALF);
        spi_sclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, input bit lsb);
        for (int k = 0; k < 8; k++) send_bit(lsb ? v[k] : v[7-k]);
    endtask

    // Clock in one read byte; flags a change of sdo during a high phase (R6)
    task automatic recv_byte(input bit lsb, output logic [7:0] v, output bit moved, output bit oe_ok);
        logic b;
        moved = 1'b0;
        oe_ok = 1'b1;
        for (int k = 0; k < 8; k++) begin
            wait_clk(HALF);
            b = spi_sdo;
            if (spi_sdo_oe !== 1'b1) oe_ok = 1'b0;
            if (lsb) v[k] = b;
            else     v[7-k] = b;
            spi_sclk = 1'b1;
            wait_clk(HALF);
            if (spi_sdo !== b) moved = 1'b1;
            spi_sclk = 1'b0;
        end
    endtask

    task automatic cs_low();
        model_lsb = model[0][6];
        wait_clk(HALF);
        spi_cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_high();
        wait_clk(HALF);
        spi_cs_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic spi_write(input logic [6:0] a, input int n, input string tag);
        logic [6:0] p;
        logic [7:0] v;
        bit         lsb;
        cs_low();
        lsb = model_lsb;
        send_byte({1'b0, a}, lsb);
        p = a;
        for (int i = 0; i < n; i++) begin
            send_byte(tx_buf[i], lsb);
            model[p] = tx_buf[i];
            p = step(p, lsb);
        end
        check({tag, " R9 oe during write"}, spi_sdo_oe, 1'b0);
        cs_high();
        p = a;
        for (int i = 0; i < n; i++) begin
            host_peek(p, v);
            check(tag, v, model[p]);
            p = step(p, lsb);
        end
    endtask

    task automatic spi_read(input logic [6:0] a, input int n, input string tag);
        logic [6:0] p;
        logic [7:0] v;
        bit         moved;
        bit         oe_ok;
        bit         lsb;
        cs_low();
        lsb = model_lsb;
        send_byte({1'b1, a}, lsb);
        p = a;
        for (int i = 0; i < n; i++) begin
            recv_byte(lsb, v, moved, oe_ok);
            check(tag, v, model[p]);
            check({tag, " R6 sdo held high phase"}, moved, 1'b0);
            check({tag, " R9 oe in read data"}, oe_ok, 1'b1);
            p = step(p, lsb);
        end
        cs_high();
        check({tag, " R9 oe after deselect"}, spi_sdo_oe, 1'b0);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] v;
        logic [6:0] a;
        int         n;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        model_lsb = 1'b0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);

        // R1: reset state
        host_peek(7'h00, v); check("R1 reg00 reset", v, 8'h00);
        host_peek(7'h45, v); check("R1 reg45 reset", v, 8'h00);
        host_peek(7'h7F, v); check("R1 reg7F reset", v, 8'h00);
        check("R1 oe reset", spi_sdo_oe, 1'b0);

        // R10: host write then host read and serial read (R2, R3 MSB-first)
        host_poke(7'h12, 8'h5A);
        host_peek(7'h12, v); check("R10 host readback", v, 8'h5A);
        spi_read(7'h12, 1, "R2 R3 msb read single");

        // R4: MSB-first multibyte write counts down
        tx_buf[0] = 8'hC1; tx_buf[1] = 8'h82; tx_buf[2] = 8'h13;
        spi_write(7'h22, 3, "R4 msb write down");
        spi_read(7'h22, 3, "R4 msb read down");

        // R4: wrap 0x00 -> 0x7F
        tx_buf[0] = 8'h00; tx_buf[1] = 8'h77;
        spi_write(7'h00, 2, "R4 wrap down");

        // R8: setting LSB mode mid-transaction keeps MSB order and down count
        tx_buf[0] = 8'h40; tx_buf[1] = 8'h3C;
        spi_write(7'h00, 2, "R8 mode change deferred");
        host_peek(7'h01, v); check("R8 reg01 untouched", v, 8'h00);

        // R5: LSB-first, wrap 0x7F -> 0x00 (keeps bit 6 set)
        tx_buf[0] = 8'h99; tx_buf[1] = 8'h41;
        spi_write(7'h7F, 2, "R5 wrap up");
        tx_buf[0] = 8'h01; tx_buf[1] = 8'h80; tx_buf[2] = 8'hE6;
        spi_write(7'h30, 3, "R5 R3 lsb write up");
        spi_read(7'h30, 3, "R5 R3 lsb read up");
        spi_read(7'h7F, 2, "R5 R2 lsb read wrap");

        // R7: abort during data and during instruction
        cs_low();
        send_byte({1'b0, 7'h40}, 1'b1);
        for (int k = 0; k < 5; k++) send_bit(1'b1);
        cs_high();
        host_peek(7'h40, v); check("R7 partial byte dropped", v, 8'h00);
        cs_low();
        for (int k = 0; k < 4; k++) send_bit(1'b1);
        cs_high();
        tx_buf[0] = 8'hA7;
        spi_write(7'h41, 1, "R7 fresh after abort");
        host_peek(7'h40, v); check("R7 neighbour intact", v, 8'h00);

        // Back to MSB-first
        tx_buf[0] = 8'h00;
        spi_write(7'h00, 1, "R8 back to msb");
        spi_read(7'h41, 1, "R3 msb read after switch");

        // Random mix
        for (int t = 0; t < 40; t++) begin
            a = 7'($urandom_range(0, 127));
            n = $urandom_range(1, 4);
            case ($urandom_range(0, 2))
                0: begin
                    for (int i = 0; i < n; i++) tx_buf[i] = 8'($urandom);
                    spi_write(a, n, "R3 R4 R5 random write");
                end
                1: spi_read(a, n, "R3 R4 R5 random read");
                default: begin
                    host_poke(a, 8'($urandom));
                    host_peek(a, v); check("R10 random host", v, model[a]);
                end
            endcase
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule